// File: doc/BRIEF.md
# Synchronizing SCL Clock Generator for an I2C Master

This block produces the SCL clock of an I2C master on an open-drain, wired-AND bus. It only pulls the line low and never drives it high. It counts its own low and high half-periods in sampling ticks. The tick comes from a two-stage divider of the system clock: a power-of-two prescale, then a divide by `brp + 1`. Both bus lines pass through a two-flop synchronizer, so every decision is made on sampled values. For reliable START/STOP detection, the tick rate should be at least ten times the fastest SCL on the bus: 1 MHz or more for 100 kHz operation, and 4 MHz or more for 400 kHz operation.

Several devices may share the clock. The local high phase ends as soon as any device pulls SCL low, and a fresh low phase starts at once. When its own low count expires, the block releases the line. It then starts counting high time only after SCL is sampled high again. The slowest device therefore sets the low time and the fastest sets the high time. A slave that stretches the clock is followed with no timeout.

A byte engine requests clocking with `run`. It receives a one-cycle strobe on each sampled rising SCL edge, where it samples data, and on each sampled falling edge, where it changes data. It also receives the synchronized SDA value.

The controller has four states:
- ST_IDLE: the line is released.
- ST_LOW: the block pulls SCL low and counts ticks.
- ST_RELEASE: the line is released and the block waits for SCL to be sampled high.
- ST_HIGH: the line is released and the block counts ticks.

The transitions are:
- start: ST_IDLE to ST_LOW, when `run` is high and SCL is sampled high.
- low_done: ST_LOW to ST_RELEASE, when the low count expires.
- line_up: ST_RELEASE to ST_HIGH, when SCL is sampled high.
- cut_short: ST_HIGH to ST_LOW, when SCL is sampled low.
- next_bit: ST_HIGH to ST_LOW, when the high count expires and `run` is high.
- stop: ST_HIGH to ST_IDLE, when the high count expires and `run` is low.

Top module: `scl_sync_gen`

## Requirements
- R1: While reset is asserted and just after it, `scl_drive_low` is 0 and neither strobe fires.
- R2: One tick lasts T = 2^`pre_sel` * (`brp`+1) clock cycles. An uncontested own low phase holds `scl_drive_low` at 1 for exactly HALF_TICKS*T cycles (HALF_TICKS defaults to 5).
- R3: On an uncontested bus, `scl_drive_low` stays 0 for exactly HALF_TICKS*T + 3 cycles between low phases. The extra 3 cycles are two synchronizer stages plus the state register.
- R4: If another device holds SCL low after the own low count expires, `scl_drive_low` stays 0 with no timeout. Once the line is released, `scl_drive_low` returns to 1 exactly HALF_TICKS*T + 3 cycles later.
- R5: If SCL falls during the high phase, `scl_drive_low` rises 3 cycles after the line falls. The new low phase lasts a full HALF_TICKS*T cycles.
- R6: Outside ST_IDLE, `scl_rise_stb` gives one one-cycle pulse for each sampled rising SCL edge, and `scl_fall_stb` does the same for each falling edge. The two never fire together.
- R7: `run` is examined only when a high phase completes. If it is low then, the block enters ST_IDLE and leaves SCL released.
- R8: In ST_IDLE with `run` high, the first low phase starts on the next edge if SCL is sampled high. If SCL is held low, the start waits until the line has been high for 3 cycles.
- R9: In ST_IDLE both strobes stay 0, whatever SCL does.
- R10: `sda_smp` follows `sda_in` two clock cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| pre_sel | input | PRE_W | Prescale exponent; the first stage divides by 2^pre_sel |
| brp | input | BRP_W | Second-stage divisor minus one |
| run | input | 1 | Clocking request from the byte engine |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| scl_drive_low | output | 1 | Enable for the open-drain SCL pull-down |
| scl_rise_stb | output | 1 | One-cycle pulse on a sampled SCL rising edge |
| scl_fall_stb | output | 1 | One-cycle pulse on a sampled SCL falling edge |
| sda_smp | output | 1 | SDA after the two-flop synchronizer |

## Verification
The bench models the wired-AND bus by combining the block's pull-down with an external pull-down. It then attacks three cases:
- A stretched low phase. A design with a hidden timeout would release early. A design that starts its high count at release instead of at the sampled high would produce a short high phase.
- A pull-down injected partway through the high phase. A design that ignores it keeps counting and shows a long high time. A design that resumes a partial low count shows a short low phase.
- Stopping mid-bit and toggling SCL while idle. These expose a block that quits in the middle of a bit, or that leaks strobes from other masters' traffic.

// File: rtl/sclg_pkg.sv
package sclg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_LOW     = 2'd1,
        ST_RELEASE = 2'd2,
        ST_HIGH    = 2'd3
    } sclg_state_e;
endpackage

// File: rtl/sclg_tick_div.sv
module sclg_tick_div #(
    parameter int PRE_W = 3,
    parameter int BRP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [PRE_W-1:0] pre_sel,
    input  logic [BRP_W-1:0] brp,
    output logic             tick
);
    localparam int PCNT_W = (1 << PRE_W) - 1;

    logic [PCNT_W-1:0] pre_cnt;
    logic [PCNT_W-1:0] pre_mask;
    logic              pre_wrap;
    logic [BRP_W-1:0]  brp_cnt;

    always_comb begin
        pre_mask = ~({PCNT_W{1'b1}} << pre_sel);
        pre_wrap = (pre_cnt == pre_mask);
        tick     = pre_wrap && (brp_cnt == brp);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt <= '0;
            brp_cnt <= '0;
        end else if (clr) begin
            pre_cnt <= '0;
            brp_cnt <= '0;
        end else begin
            pre_cnt <= pre_wrap ? '0 : pre_cnt + 1'b1;
            if (pre_wrap) begin
                brp_cnt <= (brp_cnt == brp) ? '0 : brp_cnt + 1'b1;
            end
        end
    end

    // R2
    pre_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_cnt <= pre_mask) || $past(pre_cnt > pre_mask));
endmodule

// File: rtl/sclg_line_sync.sv
module sclg_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_s,
    output logic sda_s,
    output logic scl_up,
    output logic scl_dn
);
    logic [2:0] scl_pipe;
    logic [1:0] sda_pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= 3'b111;
            sda_pipe <= 2'b11;
        end else begin
            scl_pipe <= {scl_pipe[1:0], scl_raw};
            sda_pipe <= {sda_pipe[0], sda_raw};
        end
    end

    always_comb begin
        scl_s  = scl_pipe[1];
        sda_s  = sda_pipe[1];
        scl_up = scl_pipe[1] & ~scl_pipe[2];
        scl_dn = ~scl_pipe[1] & scl_pipe[2];
    end
endmodule

// File: rtl/scl_sync_gen.sv
module scl_sync_gen #(
    parameter int PRE_W      = 3,
    parameter int BRP_W      = 8,
    parameter int HALF_TICKS = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PRE_W-1:0] pre_sel,
    input  logic [BRP_W-1:0] brp,
    input  logic             run,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             scl_drive_low,
    output logic             scl_rise_stb,
    output logic             scl_fall_stb,
    output logic             sda_smp
);
    import sclg_pkg::*;

    localparam int CNT_W = $clog2(HALF_TICKS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_TICKS - 1);

    sclg_state_e      state_q, state_d;
    logic [CNT_W-1:0] half_cnt, cnt_d;
    logic             div_clr, tick;
    logic             scl_s, scl_up, scl_dn;

    sclg_tick_div #(.PRE_W(PRE_W), .BRP_W(BRP_W)) u_div (
        .clk(clk), .rst_n(rst_n), .clr(div_clr),
        .pre_sel(pre_sel), .brp(brp), .tick(tick)
    );

    sclg_line_sync u_sync (
        .clk(clk), .rst_n(rst_n), .scl_raw(scl_in), .sda_raw(sda_in),
        .scl_s(scl_s), .sda_s(sda_smp), .scl_up(scl_up), .scl_dn(scl_dn)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            half_cnt <= '0;
        end else begin
            state_q  <= state_d;
            half_cnt <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = half_cnt;
        div_clr = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                div_clr = 1'b1;
                cnt_d   = '0;
                if (run && scl_s) state_d = ST_LOW;
            end
            ST_LOW: begin
                if (tick) begin
                    if (half_cnt == LAST) begin
                        state_d = ST_RELEASE;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = half_cnt + 1'b1;
                    end
                end
            end
            ST_RELEASE: begin
                if (scl_s) begin
                    state_d = ST_HIGH;
                    cnt_d   = '0;
                    div_clr = 1'b1;
                end
            end
            ST_HIGH: begin
                if (!scl_s) begin
                    state_d = ST_LOW;
                    cnt_d   = '0;
                    div_clr = 1'b1;
                end else if (tick) begin
                    if (half_cnt == LAST) begin
                        state_d = run ? ST_LOW : ST_IDLE;
                        cnt_d   = '0;
                        div_clr = 1'b1;
                    end else begin
                        cnt_d = half_cnt + 1'b1;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        scl_drive_low = (state_q == ST_LOW);
        scl_rise_stb  = (state_q != ST_IDLE) && scl_up;
        scl_fall_stb  = (state_q != ST_IDLE) && scl_dn;
    end

    // R2
    low_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOW) |-> (half_cnt <= LAST));
    // R4
    wait_no_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RELEASE && !scl_s) |=> (state_q == ST_RELEASE));
    // R5
    high_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HIGH && !scl_s) |=> (state_q == ST_LOW));
    // R6
    edge_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(scl_rise_stb && scl_fall_stb));
    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !run) |=> (state_q == ST_IDLE));
endmodule

// File: tb/scl_sync_gen_bench.sv
module scl_sync_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] pre_sel = '0;
    logic [7:0] brp = '0;
    logic       run = 1'b0;
    logic       ext_low = 1'b0;
    logic       sda_in = 1'b1;
    logic       scl_in;
    logic       scl_drive_low, scl_rise_stb, scl_fall_stb, sda_smp;
    int         errors = 0;
    int         checks = 0;

    always #5 clk = ~clk;

    assign scl_in = ~(scl_drive_low | ext_low);

    scl_sync_gen u_scl_sync_gen (
        .clk(clk), .rst_n(rst_n), .pre_sel(pre_sel), .brp(brp), .run(run),
        .scl_in(scl_in), .sda_in(sda_in), .scl_drive_low(scl_drive_low),
        .scl_rise_stb(scl_rise_stb), .scl_fall_stb(scl_fall_stb),
        .sda_smp(sda_smp)
    );

    // pre_sel, brp, expected low width = 5 * 2^pre_sel * (brp+1)
    localparam int NV = 5;
    localparam int VEC [NV][3] = '{
        '{0, 0, 5}, '{1, 0, 10}, '{0, 2, 15}, '{2, 1, 40}, '{3, 0, 40}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_drive(output int k, output int falls);
        k = 0;
        falls = 0;
        do begin
            @(negedge clk);
            k++;
            falls += int'(scl_fall_stb);
        end while (!scl_drive_low);
    endtask

    task automatic count_level(input logic v, output int n, output int rises,
                               output int falls);
        n = 0; rises = 0; falls = 0;
        while (scl_drive_low == v) begin
            n++;
            rises += int'(scl_rise_stb);
            falls += int'(scl_fall_stb);
            @(negedge clk);
        end
    endtask

    task automatic go_idle();
        run = 1'b0;
        repeat (300) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        int k, n, m, r, f, r2, f2, hits;
        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1 drive in reset", int'(scl_drive_low), 0);
        check("R1 strobes in reset", int'(scl_rise_stb | scl_fall_stb), 0);
        rst_n = 1'b1;
        hits = 0;
        repeat (5) begin
            @(negedge clk);
            hits += int'(scl_drive_low | scl_rise_stb | scl_fall_stb);
        end
        check("R1 quiet after reset", hits, 0);

        // Table walk: R2, R3, R6, R8
        for (int i = 0; i < NV; i++) begin
            go_idle();
            pre_sel = 3'(VEC[i][0]);
            brp     = 8'(VEC[i][1]);
            run     = 1'b1;
            wait_drive(k, f);
            check("R8 start delay", k, 1);
            count_level(1'b1, n, r, f);
            check("R2 low width", n, VEC[i][2]);
            check("R6 one fall in low", f, 1);
            count_level(1'b0, m, r, f);
            check("R3 high width", m, VEC[i][2] + 3);
            check("R6 one rise in high", r, 1);
            check("R6 no fall in high", f, 0);
        end

        // R4 stretch
        go_idle();
        pre_sel = 3'd0; brp = 8'd0; run = 1'b1;
        wait_drive(k, f);
        count_level(1'b1, n, r, f);
        ext_low = 1'b1;
        hits = 0; r = 0;
        repeat (100) begin
            @(negedge clk);
            hits += int'(scl_drive_low);
            r    += int'(scl_rise_stb);
        end
        check("R4 held released while stretched", hits, 0);
        check("R4 no rise while stretched", r, 0);
        ext_low = 1'b0;
        wait_drive(k, f);
        check("R4 resume delay", k, 8);

        // R5 high cut short
        go_idle();
        pre_sel = 3'd2; brp = 8'd1; run = 1'b1;
        wait_drive(k, f);
        count_level(1'b1, n, r, f);
        repeat (10) @(negedge clk);
        ext_low = 1'b1;
        wait_drive(k, f);
        check("R5 restart delay", k, 3);
        check("R6 fall on cut", f, 1);
        ext_low = 1'b0;
        count_level(1'b1, n, r, f);
        check("R5 full low after cut", n, 40);

        // R7 stop
        go_idle();
        pre_sel = 3'd0; brp = 8'd0; run = 1'b1;
        wait_drive(k, f);
        run = 1'b0;
        count_level(1'b1, n, r, f);
        check("R7 low completes after stop", n, 5);
        hits = 0; r = 0;
        repeat (200) begin
            @(negedge clk);
            hits += int'(scl_drive_low);
            r    += int'(scl_rise_stb);
        end
        check("R7 stays released", hits, 0);
        check("R7 final rise", r, 1);

        // R9 idle quiet
        r2 = 0; f2 = 0;
        repeat (5) begin
            ext_low = 1'b1;
            repeat (10) begin
                @(negedge clk);
                r2 += int'(scl_rise_stb); f2 += int'(scl_fall_stb);
            end
            ext_low = 1'b0;
            repeat (10) begin
                @(negedge clk);
                r2 += int'(scl_rise_stb); f2 += int'(scl_fall_stb);
            end
        end
        check("R9 no strobes idle", r2 + f2, 0);

        // R8 blocked start
        ext_low = 1'b1;
        repeat (20) @(negedge clk);
        run = 1'b1;
        hits = 0;
        repeat (50) begin
            @(negedge clk);
            hits += int'(scl_drive_low);
        end
        check("R8 no start while low", hits, 0);
        ext_low = 1'b0;
        wait_drive(k, f);
        check("R8 start after release", k, 3);
        go_idle();

        // R10 SDA sampling
        sda_in = 1'b0;
        @(negedge clk);
        check("R10 sda one cycle", int'(sda_smp), 1);
        @(negedge clk);
        check("R10 sda two cycles", int'(sda_smp), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule